// File: doc/BRIEF.md
# Fixed-Burst Queue Port for a 64-bit AXI Master

This block sits behind a 64-bit AXI slave port and puts a 32-bit first-in first-out queue behind it. Every transfer targets the single queue location, so the port has no address inputs at all. Only FIXED bursts are accepted, and every response is OKAY. IDs, exclusive access and more than one outstanding transaction are not supported.

On writes, each data beat becomes zero, one or two 32-bit pushes. The count depends on the transfer size and on which halves of the byte strobe are active. On reads, each beat pops one or two entries. A full-width read packs two entries into the 64-bit data word. A narrow read copies a single entry onto both halves of the bus. The queue storage is part of the block. A full queue stalls the write data channel, and an empty queue holds off read data.

The write engine has four states:
- `WS_ADDR` accepts the address and goes to `WS_BEAT`.
- `WS_BEAT` performs a single push, or the lower push of a split beat. It moves to `WS_UPPER` for the second half of a split beat, or to `WS_RESP` after the last beat.
- `WS_UPPER` performs the upper push and returns to `WS_BEAT`, or goes to `WS_RESP` after the last beat.
- `WS_RESP` holds the response until it is taken, then returns to `WS_ADDR`.

The read engine has four states:
- `RS_ADDR` accepts the address and goes to `RS_POP_LO`.
- `RS_POP_LO` pops the first entry. It goes to `RS_POP_HI` for a full-width beat, otherwise to `RS_SEND`.
- `RS_POP_HI` pops the second entry and goes to `RS_SEND`.
- `RS_SEND` presents the beat. It returns to `RS_POP_LO` for the next beat, or to `RS_ADDR` after the last beat.

Top module: `fixed_queue_axi_port`

## Requirements
- R1: After reset, awready and arready are 1, and wready, bvalid and rvalid are 0.
- R2: A write beat of size 3 with at least one strobe set in wstrb[3:0] and at least one in wstrb[7:4] pushes two entries: wdata[31:0] first, then wdata[63:32].
- R3: A write beat of size 3 with strobes only in wstrb[3:0] (for example 0x0F) pushes only wdata[31:0]. One with strobes only in wstrb[7:4] (for example 0xF0) pushes only wdata[63:32]. One with no strobe set pushes nothing.
- R4: In a multi-beat FIXED write burst, every beat adds new entries behind the earlier ones. Nothing is overwritten, and reads return entries in the order they were written.
- R5: A read beat of size 3 pops two entries and returns the first in rdata[31:0] and the second in rdata[63:32].
- R6: A write beat of size 2 or less pushes exactly one entry. The entry is wdata[63:32] if any bit of wstrb[7:4] is set, otherwise wdata[31:0]. A read beat of size 2 or less pops one entry and drives it on both rdata[31:0] and rdata[63:32].
- R7: While the queue is full, wready stays 0. The stalled beat is accepted once space frees, and no entry is lost.
- R8: rvalid stays 0 until the entries the beat needs are in the queue.
- R9: bvalid is 0 until the beat with wlast has been completely pushed. It then rises in the next cycle with bresp = 00, once per burst.
- R10: rlast is 1 only on beat number arlen (counting from 0), and rresp is 00. While rvalid is high and rready is low, rdata stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awlen | input | 8 | Write burst length minus one |
| awsize | input | 3 | Write transfer size code |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 64 | Write data |
| wstrb | input | 8 | Write byte strobes |
| wlast | input | 1 | Last write beat |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response, always OKAY |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| arlen | input | 8 | Read burst length minus one |
| arsize | input | 3 | Read transfer size code |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 64 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rlast | output | 1 | Last read beat |

## Verification
A wrong write-engine state shows up at the read port as a missing, doubled or swapped 32-bit half. This appears on the very next read of that entry, because queue order preserves every earlier error. A read engine that pops the wrong number of entries shifts every later read by one entry. A read engine that loses track of its beat count misplaces rlast on the same burst. A broken full or empty signal shows within a few cycles: wready is raised while the queue is full, or rvalid is raised before data exists. The R7 and R8 stall tests hold both conditions for several cycles to expose this.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
    typedef enum logic [1:0] {
        WS_ADDR,
        WS_BEAT,
        WS_UPPER,
        WS_RESP
    } wr_state_t;

    typedef enum logic [1:0] {
        RS_ADDR,
        RS_POP_LO,
        RS_POP_HI,
        RS_SEND
    } rd_state_t;

    localparam logic [2:0] SIZE_FULL = 3'd3;
    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/fxq_store.sv
module fxq_store #(
    parameter int ENTRY_W = 32,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [ENTRY_W-1:0] push_data_i,
    input  logic               pop_i,
    output logic [ENTRY_W-1:0] head_o,
    output logic               full_o,
    output logic               empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]   wptr, rptr;
    logic [CNT_W-1:0]   count;

    assign full_o  = (count == CNT_W'(DEPTH));
    assign empty_o = (count == '0);
    assign head_o  = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_i) mem[wptr] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_i) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop_i)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            unique case ({push_i, pop_i})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !push_i);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> !pop_i);
endmodule

// File: rtl/fxq_wr_ctrl.sv
module fxq_wr_ctrl
    import fxq_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                awvalid,
    output logic                awready,
    input  logic [LEN_W-1:0]    awlen,
    input  logic [2:0]          awsize,
    input  logic                wvalid,
    output logic                wready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wlast,
    output logic                bvalid,
    input  logic                bready,
    output logic                push_o,
    output logic [DATA_W/2-1:0] push_data_o,
    input  logic                full_i
);
    localparam int HALF_W = DATA_W / 2;
    localparam int HSTB_W = DATA_W / 16;

    wr_state_t        state, nxt;
    logic [2:0]       size_q;
    logic [LEN_W-1:0] len_q, beat_q;
    logic             any_lo, any_hi, wide, w_fire;

    assign any_lo = |wstrb[HSTB_W-1:0];
    assign any_hi = |wstrb[2*HSTB_W-1:HSTB_W];
    assign wide   = (size_q == SIZE_FULL);
    assign w_fire = wvalid && wready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WS_ADDR;
            size_q <= '0;
            len_q  <= '0;
            beat_q <= '0;
        end else begin
            state <= nxt;
            if (awvalid && awready) begin
                size_q <= awsize;
                len_q  <= awlen;
                beat_q <= '0;
            end else if (w_fire) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        nxt         = state;
        awready     = 1'b0;
        wready      = 1'b0;
        bvalid      = 1'b0;
        push_o      = 1'b0;
        push_data_o = wdata[HALF_W-1:0];
        unique case (state)
            WS_ADDR: begin
                awready = 1'b1;
                if (awvalid) nxt = WS_BEAT;
            end
            WS_BEAT: begin
                if (wvalid) begin
                    if (wide && any_lo && any_hi) begin
                        push_o = !full_i;
                        if (!full_i) nxt = WS_UPPER;
                    end else if (wide && !any_lo && !any_hi) begin
                        wready = 1'b1;
                        if (wlast) nxt = WS_RESP;
                    end else begin
                        push_o = !full_i;
                        wready = !full_i;
                        if (any_hi) push_data_o = wdata[DATA_W-1:HALF_W];
                        if (!full_i && wlast) nxt = WS_RESP;
                    end
                end
            end
            WS_UPPER: begin
                push_data_o = wdata[DATA_W-1:HALF_W];
                push_o      = wvalid && !full_i;
                wready      = !full_i;
                if (wvalid && !full_i) nxt = wlast ? WS_RESP : WS_BEAT;
            end
            WS_RESP: begin
                bvalid = 1'b1;
                if (bready) nxt = WS_ADDR;
            end
            default: nxt = WS_ADDR;
        endcase
    end

    p_wlast_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (w_fire && wlast) |=> bvalid);
    p_bvalid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
    p_wlast_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (w_fire && wlast) |-> (beat_q == len_q));
endmodule

// File: rtl/fxq_rd_ctrl.sv
module fxq_rd_ctrl
    import fxq_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LEN_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arvalid,
    output logic                arready,
    input  logic [LEN_W-1:0]    arlen,
    input  logic [2:0]          arsize,
    output logic                rvalid,
    input  logic                rready,
    output logic [DATA_W-1:0]   rdata,
    output logic                rlast,
    output logic                pop_o,
    input  logic [DATA_W/2-1:0] head_i,
    input  logic                empty_i
);
    localparam int HALF_W = DATA_W / 2;

    rd_state_t         state, nxt;
    logic [2:0]        size_q;
    logic [LEN_W-1:0]  len_q, beat_q;
    logic [HALF_W-1:0] lo_q, hi_q;

    assign rdata = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RS_ADDR;
            size_q <= '0;
            len_q  <= '0;
            beat_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            state <= nxt;
            if (arvalid && arready) begin
                size_q <= arsize;
                len_q  <= arlen;
                beat_q <= '0;
            end
            if (state == RS_POP_LO && !empty_i) begin
                lo_q <= head_i;
                hi_q <= head_i;
            end
            if (state == RS_POP_HI && !empty_i) hi_q <= head_i;
            if (rvalid && rready) beat_q <= beat_q + 1'b1;
        end
    end

    always_comb begin
        nxt     = state;
        arready = 1'b0;
        rvalid  = 1'b0;
        rlast   = 1'b0;
        pop_o   = 1'b0;
        unique case (state)
            RS_ADDR: begin
                arready = 1'b1;
                if (arvalid) nxt = RS_POP_LO;
            end
            RS_POP_LO: begin
                pop_o = !empty_i;
                if (!empty_i) nxt = (size_q == SIZE_FULL) ? RS_POP_HI : RS_SEND;
            end
            RS_POP_HI: begin
                pop_o = !empty_i;
                if (!empty_i) nxt = RS_SEND;
            end
            RS_SEND: begin
                rvalid = 1'b1;
                rlast  = (beat_q == len_q);
                if (rready) nxt = rlast ? RS_ADDR : RS_POP_LO;
            end
            default: nxt = RS_ADDR;
        endcase
    end

    p_rdata_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));
    p_rlast_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && rready && rlast) |=> arready);
endmodule

// File: rtl/fixed_queue_axi_port.sv
module fixed_queue_axi_port
    import fxq_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 8,
    parameter int LEN_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                awvalid,
    output logic                awready,
    input  logic [LEN_W-1:0]    awlen,
    input  logic [2:0]          awsize,
    input  logic                wvalid,
    output logic                wready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    input  logic                wlast,
    output logic                bvalid,
    input  logic                bready,
    output logic [1:0]          bresp,
    input  logic                arvalid,
    output logic                arready,
    input  logic [LEN_W-1:0]    arlen,
    input  logic [2:0]          arsize,
    output logic                rvalid,
    input  logic                rready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rlast
);
    localparam int ENTRY_W = DATA_W / 2;

    logic               push, pop, full, empty;
    logic [ENTRY_W-1:0] push_data, head;

    assign bresp = RESP_OKAY;
    assign rresp = RESP_OKAY;

    fxq_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .push_data_i(push_data),
        .pop_i(pop), .head_o(head),
        .full_o(full), .empty_o(empty)
    );

    fxq_wr_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awlen(awlen), .awsize(awsize),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready),
        .push_o(push), .push_data_o(push_data), .full_i(full)
    );

    fxq_rd_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .arvalid(arvalid), .arready(arready), .arlen(arlen), .arsize(arsize),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rlast(rlast),
        .pop_o(pop), .head_i(head), .empty_i(empty)
    );
endmodule

// File: tb/tb_fixed_queue_axi_port.sv
`timescale 1ns/1ps
module tb_fixed_queue_axi_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awvalid = 0, awready;
    logic [7:0]  awlen = 0;
    logic [2:0]  awsize = 0;
    logic        wvalid = 0, wready;
    logic [63:0] wdata = 0;
    logic [7:0]  wstrb = 0;
    logic        wlast = 0;
    logic        bvalid, bready = 0;
    logic [1:0]  bresp;
    logic        arvalid = 0, arready;
    logic [7:0]  arlen = 0;
    logic [2:0]  arsize = 0;
    logic        rvalid, rready = 0;
    logic [63:0] rdata;
    logic [1:0]  rresp;
    logic        rlast;

    int checks = 0;
    int errors = 0;

    logic [63:0] wb_data [16];
    logic [7:0]  wb_strb [16];
    logic [63:0] rb_data [16];
    logic        rb_last [16];
    logic [1:0]  rb_resp [16];

    always #2.5 clk = ~clk;

    fixed_queue_axi_port dut (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awready(awready), .awlen(awlen), .awsize(awsize),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .arlen(arlen), .arsize(arsize),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast)
    );

    typedef struct packed {
        logic [2:0]  sz;
        logic [7:0]  strb;
        logic [63:0] data;
        logic [1:0]  n;
        logic [31:0] e0;
        logic [31:0] e1;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd3, 8'hFF, 64'h1111_2222_3333_4444, 2'd2, 32'h3333_4444, 32'h1111_2222}, // R2
        '{3'd3, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD, 2'd1, 32'hCCCC_DDDD, 32'h0},         // R3
        '{3'd3, 8'hF0, 64'h5555_6666_7777_8888, 2'd1, 32'h5555_6666, 32'h0},         // R3
        '{3'd3, 8'h00, 64'hDEAD_DEAD_DEAD_DEAD, 2'd0, 32'h0,         32'h0},         // R3
        '{3'd2, 8'hF0, 64'h0BAD_F00D_0000_0001, 2'd1, 32'h0BAD_F00D, 32'h0},         // R6
        '{3'd1, 8'h03, 64'h9999_9999_1234_ABCD, 2'd1, 32'h1234_ABCD, 32'h0}          // R6
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input int nbeats, input logic [2:0] sz);
        @(negedge clk);
        awvalid = 1; awlen = 8'(nbeats - 1); awsize = sz;
        #1;
        while (!awready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        awvalid = 0;
        for (int b = 0; b < nbeats; b++) begin
            wvalid = 1; wdata = wb_data[b]; wstrb = wb_strb[b]; wlast = (b == nbeats - 1);
            #1;
            while (!wready) begin @(negedge clk); #1; end
            @(posedge clk); @(negedge clk);
            wvalid = 0; wlast = 0;
            if (b != nbeats - 1) chk(bvalid == 1'b0, "R9 early bvalid", 64'(bvalid), 64'd0);
        end
        chk(bvalid == 1'b1, "R9 bvalid after last", 64'(bvalid), 64'd1);
        chk(bresp == 2'b00, "R9 bresp", 64'(bresp), 64'd0);
        bready = 1;
        @(posedge clk); @(negedge clk);
        bready = 0;
    endtask

    task automatic do_read(input int nbeats, input logic [2:0] sz);
        @(negedge clk);
        arvalid = 1; arlen = 8'(nbeats - 1); arsize = sz;
        #1;
        while (!arready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        arvalid = 0;
        for (int b = 0; b < nbeats; b++) begin
            rready = 1;
            #1;
            while (!rvalid) begin @(negedge clk); #1; end
            rb_data[b] = rdata; rb_last[b] = rlast; rb_resp[b] = rresp;
            @(posedge clk); @(negedge clk);
            rready = 0;
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hang expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] e;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;

        // R1 reset state
        chk(awready == 1'b1, "R1 awready", 64'(awready), 64'd1);
        chk(arready == 1'b1, "R1 arready", 64'(arready), 64'd1);
        chk(wready == 1'b0, "R1 wready", 64'(wready), 64'd0);
        chk(bvalid == 1'b0, "R1 bvalid", 64'(bvalid), 64'd0);
        chk(rvalid == 1'b0, "R1 rvalid", 64'(rvalid), 64'd0);

        // Table walk: one-beat write, then read back entries one narrow beat at a time (R2 R3 R6)
        for (int v = 0; v < 6; v++) begin
            wb_data[0] = VECS[v].data; wb_strb[0] = VECS[v].strb;
            do_write(1, VECS[v].sz);
            for (int k = 0; k < int'(VECS[v].n); k++) begin
                e = (k == 0) ? VECS[v].e0 : VECS[v].e1;
                do_read(1, 3'd2);
                chk(rb_data[0] == {e, e}, "R2 R3 R6 entry value/order", rb_data[0], {e, e});
                chk(rb_last[0] == 1'b1 && rb_resp[0] == 2'b00, "R10 single beat rlast/rresp",
                    64'({rb_last[0], rb_resp[0]}), 64'b100);
            end
        end

        // R4 multi-beat narrow burst, read back as a narrow burst with R10 rlast placement
        for (int b = 0; b < 4; b++) begin
            wb_data[b] = {32'hFFFF_FFFF, 32'hA000_0000 + 32'(b)};
            wb_strb[b] = 8'h0F;
        end
        do_write(4, 3'd2);
        do_read(4, 3'd2);
        for (int b = 0; b < 4; b++) begin
            e = 32'hA000_0000 + 32'(b);
            chk(rb_data[b] == {e, e}, "R4 burst order", rb_data[b], {e, e});
            chk(rb_last[b] == (b == 3), "R10 rlast position", 64'(rb_last[b]), 64'(b == 3));
        end

        // R5 full-width read burst of two beats packs pairs, lower entry first
        for (int b = 0; b < 2; b++) begin
            wb_data[b] = {32'hB000_0001 + 32'(2*b), 32'hB000_0000 + 32'(2*b)};
            wb_strb[b] = 8'hFF;
        end
        do_write(2, 3'd3);
        do_read(2, 3'd3);
        chk(rb_data[0] == 64'hB000_0001_B000_0000, "R5 beat0 packing", rb_data[0], 64'hB000_0001_B000_0000);
        chk(rb_data[1] == 64'hB000_0003_B000_0002, "R5 beat1 packing", rb_data[1], 64'hB000_0003_B000_0002);
        chk(rb_last[0] == 1'b0 && rb_last[1] == 1'b1, "R10 rlast on arlen", 64'({rb_last[0], rb_last[1]}), 64'b01);

        // R8 read on empty queue: rvalid stays low until data arrives
        wb_data[0] = {32'h0, 32'hC0DE_0008}; wb_strb[0] = 8'h0F;
        fork
            do_read(1, 3'd2);
            begin
                repeat (6) @(negedge clk);
                #1;
                chk(rvalid == 1'b0, "R8 rvalid held on empty", 64'(rvalid), 64'd0);
                do_write(1, 3'd2);
            end
        join
        chk(rb_data[0] == {2{32'hC0DE_0008}}, "R8 late data", rb_data[0], {2{32'hC0DE_0008}});

        // R7 fill queue (depth 8), then stall a write until a pop frees space
        for (int b = 0; b < 8; b++) begin
            wb_data[b] = {32'h0, 32'h100 + 32'(b)};
            wb_strb[b] = 8'h0F;
        end
        do_write(8, 3'd2);
        wb_data[0] = {32'h0, 32'h1FF}; wb_strb[0] = 8'h0F;
        fork
            do_write(1, 3'd2);
            begin
                repeat (5) @(negedge clk);
                #1;
                chk(wready == 1'b0, "R7 wready held while full", 64'(wready), 64'd0);
                do_read(1, 3'd2);
                chk(rb_data[0] == {2{32'h100}}, "R7 head entry", rb_data[0], {2{32'h100}});
            end
        join
        do_read(8, 3'd2);
        for (int b = 0; b < 8; b++) begin
            e = (b == 7) ? 32'h1FF : 32'h101 + 32'(b);
            chk(rb_data[b] == {e, e}, "R7 no loss after stall", rb_data[b], {e, e});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule